// File: doc/BRIEF.md
# Cache ECC Error Reporting Registers

This block collects error-correction events from a cache and keeps them until software looks at them. The cache's tag directory and its data array each report two kinds of event, corrected and uncorrectable, so there are four event sources. Each source delivers a one-cycle strobe and the 64-bit address that failed. For every source the block keeps the last failing address, a saturating event counter and a level interrupt line. Software reads the address through two 32-bit words. It then reads the count, which returns the number of events since the previous count read, clears the counter and drops that source's interrupt.

A small 32-bit register bus reaches the event registers and three more registers. The first is a read-only geometry word that describes the cache. The second is a read-only word that gives the index of the highest enabled way. The third is an error-injection request that the cache consumes to flip one chosen bit on its next access.

Top module: `ecc_err_regs`

## Requirements
- R1: After reset every counter, every latched address, all four interrupt lines and the injection request (`inj_valid`, `inj_dir`, `inj_bit`) are zero.
- R2: On an event strobe the source captures the 64-bit failing address. Bits [31:0] are read at the source's base offset and bits [63:32] at base+4. The bases are 0x100 for directory corrected, 0x120 for directory uncorrectable, 0x140 for data corrected and 0x160 for data uncorrectable.
- R3: Each event increments that source's counter, which is read at base+8. The counter is CNT_W bits wide and holds at all ones once it gets there.
- R4: An event sets that source's interrupt, and the interrupt stays set until that source's count is read. Interrupt bits map to sources as follows: bit 0 directory corrected, bit 1 data corrected, bit 2 data uncorrectable, bit 3 directory uncorrectable.
- R5: A count read returns the count held before the read. From the next cycle the counter is 0 and that source's interrupt is low. No other source is affected.
- R6: If an event arrives in the same cycle as its source's count read, the read returns the old count, the interrupt stays high and the counter becomes 1.
- R7: Offset 0x00 reads as {log2 bytes per block [31:24], log2 sets per bank [23:16], way count [15:8], bank count [7:0]}, taken from the parameters.
- R8: Offset 0x08 reads as the index of the highest enabled way in bits [7:0], with zeros above. Writes to it have no effect.
- R9: A write to 0x40 whose bits [7:0] are below 0xFF, whose bit 16 may be either value and whose other bits are zero raises `inj_valid`. In the same update `inj_dir` takes bit 16 (1 means directory, 0 means data) and `inj_bit` takes bits [7:0]. The request stays until `inj_take` is high while no legal write occurs. A legal write in the same cycle as `inj_take` wins. Reading 0x40 returns {inj_valid [31], inj_dir [16], inj_bit [7:0]}.
- R10: A write to 0x40 with any other value leaves the injection request unchanged.
- R11: Reads of unmapped offsets return zero, and writes to every offset other than 0x40 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 4 | Event strobes, using the same bit order as `irq` |
| evt_addr | input | 256 | Failing addresses; source i uses bits [64*i+63:64*i] |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| irq | output | 4 | Per-source interrupt levels |
| inj_take | input | 1 | The cache has consumed the injection request |
| inj_valid | output | 1 | An injection request is pending |
| inj_dir | output | 1 | 1 = inject into the directory, 0 = into the data array |
| inj_bit | output | 8 | Index of the bit to flip |

## Verification
The hardest case to produce is a count read that lands in the same cycle as a new event on that same source, because it needs the bus and the event path to line up exactly. The random stimulus fires events and count reads independently every cycle so that this overlap happens often, and one directed step forces it on purpose. Counter saturation needs a long run of events with no read in between. To keep that run short, the bench builds the block with a 4-bit counter and sends twenty events in a row.

// File: rtl/ecc_err_regs.sv
module ecc_err_regs #(
  parameter int CNT_W    = 32,
  parameter int BANKS    = 1,
  parameter int WAYS     = 16,
  parameter int LOG_SETS = 11,
  parameter int LOG_BLK  = 6,
  parameter int LAST_WAY = WAYS - 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   evt_valid,
  input  logic [255:0] evt_addr,
  input  logic         bus_sel,
  input  logic         bus_wr,
  input  logic [11:0]  bus_addr,
  input  logic [31:0]  bus_wdata,
  output logic [31:0]  bus_rdata,
  output logic [3:0]   irq,
  input  logic         inj_take,
  output logic         inj_valid,
  output logic         inj_dir,
  output logic [7:0]   inj_bit
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [31:0] GEOM = {8'(LOG_BLK), 8'(LOG_SETS), 8'(WAYS), 8'(BANKS)};

  function automatic logic [11:0] src_base(input int i);
    case (i)
      0:       return 12'h100;
      1:       return 12'h140;
      2:       return 12'h160;
      default: return 12'h120;
    endcase
  endfunction

  logic [63:0]      addr_q [4];
  logic [CNT_W-1:0] cnt_q  [4];
  logic [3:0]       cnt_rd;

  wire rd       = bus_sel & ~bus_wr;
  wire inj_wr   = bus_sel & bus_wr & (bus_addr == 12'h040);
  wire inj_ok   = (bus_wdata[31:17] == '0) && (bus_wdata[15:8] == '0) && (bus_wdata[7:0] != 8'hFF);
  wire inj_load = inj_wr & inj_ok;

  for (genvar i = 0; i < 4; i++) begin : g_src
    assign cnt_rd[i] = rd & (bus_addr == src_base(i) + 12'h8);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_q[i] <= '0;
        cnt_q[i]  <= '0;
        irq[i]    <= 1'b0;
      end else if (evt_valid[i]) begin
        addr_q[i] <= evt_addr[i*64 +: 64];
        cnt_q[i]  <= cnt_rd[i] ? CNT_W'(1) : (cnt_q[i] == CNT_MAX ? cnt_q[i] : cnt_q[i] + 1'b1);
        irq[i]    <= 1'b1;
      end else if (cnt_rd[i]) begin
        cnt_q[i]  <= '0;
        irq[i]    <= 1'b0;
      end
    end

    // R3
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[i] == CNT_MAX && !cnt_rd[i]) |=> cnt_q[i] == CNT_MAX);
    // R4
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[i] && !cnt_rd[i]) |=> irq[i]);
    // R5
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_rd[i] && !evt_valid[i]) |=> (!irq[i] && cnt_q[i] == '0));
    // R6
    rd_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_rd[i] && evt_valid[i]) |=> (irq[i] && cnt_q[i] == CNT_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inj_valid <= 1'b0;
      inj_dir   <= 1'b0;
      inj_bit   <= '0;
    end else if (inj_load) begin
      inj_valid <= 1'b1;
      inj_dir   <= bus_wdata[16];
      inj_bit   <= bus_wdata[7:0];
    end else if (inj_take) begin
      inj_valid <= 1'b0;
    end
  end

  // R9
  inj_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && inj_take && !inj_load) |=> !inj_valid);
  // R10
  inj_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_wr && !inj_ok && !inj_take) |=> $stable({inj_valid, inj_dir, inj_bit}));

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_addr)
        12'h000: bus_rdata = GEOM;
        12'h008: bus_rdata = {24'b0, 8'(LAST_WAY)};
        12'h040: bus_rdata = {inj_valid, 14'b0, inj_dir, 8'b0, inj_bit};
        default: ;
      endcase
      for (int i = 0; i < 4; i++) begin
        if (bus_addr == src_base(i))         bus_rdata = addr_q[i][31:0];
        if (bus_addr == src_base(i) + 12'h4) bus_rdata = addr_q[i][63:32];
        if (bus_addr == src_base(i) + 12'h8) bus_rdata = 32'(cnt_q[i]);
      end
    end
  end

endmodule

// File: tb/test_ecc_err_regs.sv
module test_ecc_err_regs;
  localparam int CW = 4, NB = 2, NW = 8, LS = 9, LB = 6, LW = 5;
  localparam int CMAX = 15;

  logic clk = 0, rst_n = 0;
  logic [3:0] evt_valid = '0;
  logic [255:0] evt_addr = '0;
  logic bus_sel = 0, bus_wr = 0, inj_take = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [3:0] irq;
  logic inj_valid, inj_dir;
  logic [7:0] inj_bit;

  ecc_err_regs #(.CNT_W(CW), .BANKS(NB), .WAYS(NW), .LOG_SETS(LS), .LOG_BLK(LB), .LAST_WAY(LW)) i_ecc_err_regs (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_addr(evt_addr),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .inj_take(inj_take),
    .inj_valid(inj_valid), .inj_dir(inj_dir), .inj_bit(inj_bit));

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  int m_cnt [4];
  logic [63:0] m_addr [4];
  logic [3:0] m_irq;
  logic m_iv, m_id;
  logic [7:0] m_ib;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] base(input int i);
    case (i)
      0: return 12'h100;
      1: return 12'h140;
      2: return 12'h160;
      default: return 12'h120;
    endcase
  endfunction

  function automatic logic [31:0] exp_reg(input logic [11:0] a);
    if (a == 12'h000) return {8'(LB), 8'(LS), 8'(NW), 8'(NB)};
    if (a == 12'h008) return 32'(LW);
    if (a == 12'h040) return {m_iv, 14'b0, m_id, 8'b0, m_ib};
    for (int i = 0; i < 4; i++) begin
      if (a == base(i)) return m_addr[i][31:0];
      if (a == base(i) + 12'h4) return m_addr[i][63:32];
      if (a == base(i) + 12'h8) return 32'(m_cnt[i]);
    end
    return 32'h0;
  endfunction

  function automatic bit inj_legal(input logic [31:0] v);
    return v[31:17] == 0 && v[15:8] == 0 && v[7:0] != 8'hFF;
  endfunction

  // one bus/event cycle; inputs driven after a negedge, results checked at the next negedge
  task automatic cyc(input logic [3:0] ev, input logic [255:0] ad, input logic sel, input logic wr,
                     input logic [11:0] ra, input logic [31:0] wd, input logic take, input string tag);
    logic [31:0] expv;
    expv = exp_reg(ra);
    evt_valid = ev; evt_addr = ad; bus_sel = sel; bus_wr = wr; bus_addr = ra; bus_wdata = wd; inj_take = take;
    #1;
    if (sel && !wr) check(tag, bus_rdata, expv);
    @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      bit crd;
      crd = sel && !wr && ra == base(i) + 12'h8;
      if (ev[i]) begin
        m_addr[i] = ad[i*64 +: 64];
        m_cnt[i] = crd ? 1 : (m_cnt[i] == CMAX ? CMAX : m_cnt[i] + 1);
        m_irq[i] = 1'b1;
      end else if (crd) begin
        m_cnt[i] = 0;
        m_irq[i] = 1'b0;
      end
    end
    if (sel && wr && ra == 12'h040 && inj_legal(wd)) begin
      m_iv = 1; m_id = wd[16]; m_ib = wd[7:0];
    end else if (take) m_iv = 0;
    @(negedge clk);
    evt_valid = '0; bus_sel = 0; bus_wr = 0; inj_take = 0;
    check("R4 irq", 32'(irq), 32'(m_irq));
    check("R9 inj", {inj_valid, 14'b0, inj_dir, 8'b0, inj_bit}, {m_iv, 14'b0, m_id, 8'b0, m_ib});
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    cyc(4'b0, '0, 1'b1, 1'b0, a, 32'h0, 1'b0, tag);
  endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    cyc(4'b0, '0, 1'b1, 1'b1, a, d, 1'b0, tag);
  endtask
  task automatic ev1(input int s, input logic [63:0] a);
    logic [255:0] ad;
    ad = '0; ad[s*64 +: 64] = a;
    cyc(4'(1 << s), ad, 1'b0, 1'b0, 12'h0, 32'h0, 1'b0, "R3 event");
  endtask

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_addr[i] = '0; end
    m_irq = '0; m_iv = 0; m_id = 0; m_ib = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 inj", {31'b0, inj_valid}, 32'h0);
    for (int i = 0; i < 4; i++) begin
      rd(base(i), "R1 addr lo");
      rd(base(i) + 12'h8, "R1 count");
    end
    // R2 address capture, directory uncorrectable
    ev1(3, 64'h1234_5678_9ABC_DEF0);
    rd(12'h120, "R2 addr lo");
    rd(12'h124, "R2 addr hi");
    // R4 ordering: data corrected is irq bit 1; reading another count leaves it
    ev1(1, 64'hAAAA_0000_5555_1111);
    check("R4 index", 32'(irq), 32'b1010);
    rd(12'h108, "R5 other count");
    rd(12'h148, "R5 count");
    rd(12'h128, "R5 count");
    check("R5 cleared", 32'(irq), 32'h0);
    // R3 saturation
    for (int k = 0; k < 20; k++) ev1(2, 64'(k));
    rd(12'h168, "R3 saturate");
    // R6 race
    ev1(0, 64'h5);
    ev1(0, 64'h6);
    cyc(4'b0001, 256'h7, 1'b1, 1'b0, 12'h108, 32'h0, 1'b0, "R6 race read");
    check("R6 irq", 32'(irq[0]), 32'h1);
    rd(12'h108, "R6 count one");
    // R7, R8, R11
    rd(12'h000, "R7 geometry");
    wr(12'h008, 32'hFFFF_FFFF, "R8 write");
    rd(12'h008, "R8 way");
    wr(12'h100, 32'hDEAD_BEEF, "R11 write");
    rd(12'h100, "R11 addr unchanged");
    rd(12'h10C, "R11 hole");
    rd(12'h200, "R11 hole");
    // R9, R10 injection
    wr(12'h040, 32'h0001_0005, "R9 write");
    rd(12'h040, "R9 readback");
    wr(12'h040, 32'h0000_00FF, "R10 bad");
    wr(12'h040, 32'h0002_0001, "R10 bad");
    rd(12'h040, "R10 readback");
    cyc(4'b0, '0, 1'b0, 1'b0, 12'h0, 32'h0, 1'b1, "R9 take");
    wr(12'h040, 32'h0000_00FE, "R9 write data");
    cyc(4'b0, '0, 1'b1, 1'b1, 12'h040, 32'h0001_0003, 1'b1, "R9 write beats take");
    // random mix
    for (int it = 0; it < 600; it++) begin
      logic [3:0] ev;
      logic [255:0] ad;
      logic sel, w, tk;
      logic [11:0] ra;
      logic [31:0] wd;
      int s, sel_k;
      ev = ($urandom % 2) ? 4'($urandom) : 4'b0;
      for (int j = 0; j < 8; j++) ad[j*32 +: 32] = $urandom;
      s = $urandom % 4;
      sel_k = $urandom % 6;
      sel = sel_k < 4;
      w = sel_k == 3;
      case ($urandom % 4)
        0: ra = base(s);
        1: ra = base(s) + 12'h4;
        default: ra = base(s) + 12'h8;
      endcase
      if (w) ra = 12'h040;
      case ($urandom % 3)
        0: wd = 32'($urandom % 256);
        1: wd = 32'h10000 | 32'($urandom % 256);
        default: wd = $urandom;
      endcase
      tk = ($urandom % 4) == 0;
      cyc(ev, ad, sel, w, ra, wd, tk, "R2 R3 R5 R6 random");
    end
    for (int i = 0; i < 4; i++) rd(base(i) + 12'h8, "R3 final count");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule